// File: doc/BRIEF.md
# Signed widening vector reduction adder

This block adds together all signed integer lanes of a vector operand and returns one scalar result. The result is twice as wide as a lane. Two encoding fields set the shape of the operand. A two-bit lane-size code selects 8-, 16- or 32-bit lanes. A width bit selects whether the lower 64 bits or the full 128 bits of the operand take part. Some combinations of the two fields are reserved. For those, the block raises an undefined-encoding flag in place of a sum.

The datapath is a fixed two-stage pipeline. In the first stage, each 32-bit word of the operand is reduced to a sign-extended partial sum for the selected lane width. Words outside the active width contribute nothing. In the second stage, the partial sums are added, the total is cut to the result width and the bus is zero-padded. Every accepted strobe takes the same number of cycles, whatever the data. The block accepts a new operand on every cycle.

Top module: `vred_sum_widen`

## Requirements
- R1: The lane width is set by `in_size`: code 0 gives 8-bit lanes, code 1 gives 16-bit lanes, code 2 gives 32-bit lanes. Lane k takes operand bits starting at k times the lane width.
- R2: When `in_wide` is 0, only operand bits 63:0 are summed and bits 127:64 have no effect on the result. When `in_wide` is 1, all 128 bits are summed.
- R3: A size code of 3 is an undefined encoding for either value of `in_wide`.
- R4: Size code 2 with `in_wide` equal to 0 is an undefined encoding. Size code 2 with `in_wide` equal to 1 is legal.
- R5: Every lane is read as a two's-complement signed value and sign-extended before it is added.
- R6: The exact sum is cut to its low 16, 32 or 64 bits for lane widths 8, 16 or 32. Bus bits above that width are zero.
- R7: For an undefined encoding, `out_undef` is 1 in the same cycle as `out_valid` and `out_result` is all zero. For a legal encoding, `out_undef` is 0.
- R8: `out_valid` goes high exactly two rising clock edges after the edge that samples `in_valid`, for any operand value. Back-to-back strobes produce back-to-back results in order.
- R9: A synchronous active-high `rst` clears both pipeline valid flags. A strobe still in flight when reset is asserted produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and encoding fields are presented this cycle |
| in_size | input | 2 | Lane-size code (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: reserved) |
| in_wide | input | 1 | 0: 64-bit operand, 1: 128-bit operand |
| in_operand | input | 128 | Vector operand, lane 0 in the least significant bits |
| out_valid | output | 1 | Result available |
| out_undef | output | 1 | The sampled encoding was undefined |
| out_result | output | 64 | Truncated sum, zero above the result width |

## Verification
The assertions assume two things about the inputs. The encoding fields are known whenever `in_valid` is high. `rst` is held for at least one edge before data is driven, so checks that look one cycle back never reach values from before reset. The bench drives every input at the falling edge. It keeps `rst` high during the first edges, and it sets size, width and operand together with the strobe. Every size and width pair is swept, the reserved ones included, so the undefined-encoding checks see both legal and illegal inputs.

// File: rtl/vred_pkg.sv
package vred_pkg;

    typedef enum logic [1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_BAD = 2'd3
    } lane_w_e;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned PART_W = WORD_W + 2;

endpackage

// File: rtl/vred_decode.sv
module vred_decode
    import vred_pkg::*;
(
    input  logic [1:0] size_code,
    input  logic       wide,
    output lane_w_e    lane_w,
    output logic       undef
);

    always_comb begin
        lane_w = LW_BAD;
        undef  = 1'b1;
        unique case (size_code)
            2'd0: begin
                lane_w = LW_8;
                undef  = 1'b0;
            end
            2'd1: begin
                lane_w = LW_16;
                undef  = 1'b0;
            end
            2'd2: begin
                lane_w = LW_32;
                undef  = !wide;
            end
            2'd3: begin
                lane_w = LW_BAD;
                undef  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/vred_word_sum.sv
module vred_word_sum
    import vred_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  lane_w_e           lane_w,
    input  logic              enable,
    output logic [PART_W-1:0] part
);

    logic [PART_W-1:0] acc;

    always_comb begin
        acc = '0;
        unique case (lane_w)
            LW_8: begin
                for (int i = 0; i < WORD_W / 8; i++) begin
                    acc = acc + {{(PART_W - 8){word[8*i + 7]}}, word[8*i +: 8]};
                end
            end
            LW_16: begin
                for (int i = 0; i < WORD_W / 16; i++) begin
                    acc = acc + {{(PART_W - 16){word[16*i + 15]}}, word[16*i +: 16]};
                end
            end
            LW_32: begin
                acc = {{(PART_W - 32){word[31]}}, word};
            end
            LW_BAD: begin
                acc = '0;
            end
        endcase
        part = enable ? acc : '0;
    end

endmodule

// File: rtl/vred_final.sv
module vred_final
    import vred_pkg::*;
#(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned RES_W   = 64
) (
    input  logic [N_WORDS-1:0][PART_W-1:0] parts,
    input  lane_w_e                        lane_w,
    input  logic                           undef,
    output logic [RES_W-1:0]               result
);

    localparam int unsigned TOT_W = PART_W + $clog2(N_WORDS);

    logic [TOT_W-1:0] total;

    always_comb begin
        total = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            total = total + {{(TOT_W - PART_W){parts[w][PART_W-1]}}, parts[w]};
        end
    end

    always_comb begin
        result = '0;
        if (!undef) begin
            unique case (lane_w)
                LW_8:   result = {{(RES_W - 16){1'b0}}, total[15:0]};
                LW_16:  result = {{(RES_W - 32){1'b0}}, total[31:0]};
                LW_32:  result = {{(RES_W - TOT_W){total[TOT_W-1]}}, total};
                LW_BAD: result = '0;
            endcase
        end
    end

endmodule

// File: rtl/vred_sum_widen.sv
module vred_sum_widen
    import vred_pkg::*;
#(
    parameter int unsigned VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_size,
    input  logic             in_wide,
    input  logic [VEC_W-1:0] in_operand,
    output logic             out_valid,
    output logic             out_undef,
    output logic [63:0]      out_result
);

    localparam int unsigned N_WORDS  = VEC_W / WORD_W;
    localparam int unsigned HALF_WDS = N_WORDS / 2;
    localparam int unsigned RES_W    = 2 * WORD_W;

    lane_w_e                        dec_lw;
    logic                           dec_undef;
    logic [N_WORDS-1:0][PART_W-1:0] parts_c;

    logic                           s1_valid;
    logic                           s1_undef;
    lane_w_e                        s1_lw;
    logic [N_WORDS-1:0][PART_W-1:0] s1_parts;
    logic [RES_W-1:0]               fin_c;

    vred_decode u_decode (
        .size_code (in_size),
        .wide      (in_wide),
        .lane_w    (dec_lw),
        .undef     (dec_undef)
    );

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        vred_word_sum u_ws (
            .word   (in_operand[w*WORD_W +: WORD_W]),
            .lane_w (dec_lw),
            .enable (in_wide || (w < HALF_WDS)),
            .part   (parts_c[w])
        );
    end

    // Stage 1: partial sums per word
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        s1_undef <= dec_undef;
        s1_lw    <= dec_lw;
        s1_parts <= parts_c;
    end

    vred_final #(
        .N_WORDS (N_WORDS),
        .RES_W   (RES_W)
    ) u_final (
        .parts  (s1_parts),
        .lane_w (s1_lw),
        .undef  (s1_undef),
        .result (fin_c)
    );

    // Stage 2: total, cut and pad
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_undef  <= s1_valid && s1_undef;
        out_result <= fin_c;
    end

    AST_SIZE3_UNDEF: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(in_valid) && ($past(in_size) == 2'd3) |-> s1_undef); // R3

    AST_NARROW32_UNDEF: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(in_valid) && ($past(in_size) == 2'd2) && !$past(in_wide)
        |-> s1_undef); // R4

    AST_NARROW_PAD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && out_valid && !out_undef && ($past(s1_lw) == LW_8)
        |-> (out_result[63:16] == '0)); // R6

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (out_valid && (out_result == '0))); // R7

    AST_S1_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s1_valid == $past(in_valid))); // R8

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(s1_valid))); // R8

endmodule

// File: tb/tb_vred_sum_widen.sv
`timescale 1ns/1ps
module tb_vred_sum_widen;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_size = 2'd0;
    logic         in_wide = 1'b0;
    logic [127:0] in_operand = '0;
    logic         out_valid;
    logic         out_undef;
    logic [63:0]  out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vred_sum_widen dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_size    (in_size),
        .in_wide    (in_wide),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_undef  (out_undef),
        .out_result (out_result)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit model_undef(input logic [1:0] sz, input logic wd);
        return (sz == 2'd3) || (sz == 2'd2 && !wd);
    endfunction

    function automatic logic [63:0] model_sum(input logic [1:0] sz, input logic wd,
                                              input logic [127:0] op);
        int esize = 8 << sz;
        int n = (wd ? 128 : 64) / esize;
        longint s = 0;
        if (model_undef(sz, wd)) return 64'd0;
        for (int e = 0; e < n; e++) begin
            logic [31:0] raw = op[e*esize +: 32 >> 0] ;
            longint v;
            raw = 32'(op >> (e * esize));
            if (esize == 8)       v = longint'($signed(raw[7:0]));
            else if (esize == 16) v = longint'($signed(raw[15:0]));
            else                  v = longint'($signed(raw));
            s += v;
        end
        if (esize == 8)  return {48'd0, s[15:0]};
        if (esize == 16) return {32'd0, s[31:0]};
        return s;
    endfunction

    function automatic logic [127:0] pat_min(input logic [1:0] sz);
        logic [127:0] p = '0;
        int esize = 8 << (sz == 2'd3 ? 2'd0 : sz);
        for (int e = 0; e < 128 / esize; e++) p[e*esize + esize - 1] = 1'b1;
        return p;
    endfunction

    function automatic logic [127:0] pat_alt(input logic [1:0] sz);
        logic [127:0] mn = pat_min(sz);
        logic [127:0] p = '0;
        int esize = 8 << (sz == 2'd3 ? 2'd0 : sz);
        for (int e = 0; e < 128 / esize; e++) begin
            for (int b = 0; b < esize; b++) begin
                if (e % 2 == 0) p[e*esize + b] = ~mn[e*esize + b];
                else            p[e*esize + b] = mn[e*esize + b];
            end
        end
        return p;
    endfunction

    task automatic run_one(input logic [1:0] sz, input logic wd, input logic [127:0] op,
                           input string req);
        logic [63:0] exp_r = model_sum(sz, wd, op);
        bit exp_u = model_undef(sz, wd);
        @(negedge clk);
        in_size = sz; in_wide = wd; in_operand = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 no result after one edge", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        chk("R8 valid after two edges", {63'd0, out_valid}, 64'd1);
        chk(exp_u ? "R3/R4 undef flag R7" : "R7 undef flag low", {63'd0, out_undef},
            {63'd0, exp_u});
        chk(req, out_result, exp_r);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset state", {63'd0, out_valid}, 64'd0);

        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
                logic [1:0] sz = 2'(s);
                logic wd = w[0];
                run_one(sz, wd, pat_min(sz), "R5 R6 all-minimum lanes");
                run_one(sz, wd, ~pat_min(sz), "R1 R6 all-maximum lanes");
                run_one(sz, wd, pat_alt(sz), "R5 alternating signs");
                run_one(sz, wd, '1, "R5 all lanes minus one");
                for (int r = 0; r < 16; r++) begin
                    run_one(sz, wd, {$urandom, $urandom, $urandom, $urandom},
                            wd ? "R1 R2 random wide" : "R2 random narrow, upper ignored");
                end
            end
        end

        // R2: upper half changes, result must not
        begin
            logic [63:0] lo = {$urandom, $urandom};
            run_one(2'd1, 1'b0, {64'd0, lo}, "R2 upper zero");
            run_one(2'd1, 1'b0, {~64'd0, lo}, "R2 upper ones");
        end
        // R3: reserved size code, nonzero data, both widths
        run_one(2'd3, 1'b1, ~pat_min(2'd0), "R3 size 3 wide result zero");
        run_one(2'd3, 1'b0, ~pat_min(2'd0), "R3 size 3 narrow result zero");
        // R4: legal vs illegal 32-bit lanes
        run_one(2'd2, 1'b0, {4{32'h7fff_ffff}}, "R4 two 32-bit lanes undefined");
        run_one(2'd2, 1'b1, {4{32'h7fff_ffff}}, "R4 four 32-bit lanes legal");

        // R8: back-to-back strobes
        begin
            logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] c = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
            in_valid = 1'b1; in_size = 2'd0; in_wide = 1'b1; in_operand = a;
            @(negedge clk);
            in_size = 2'd2; in_operand = b;
            @(negedge clk);
            chk("R8 burst first valid", {63'd0, out_valid}, 64'd1);
            chk("R8 burst first value", out_result, model_sum(2'd0, 1'b1, a));
            in_size = 2'd1; in_wide = 1'b0; in_operand = c;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R8 burst second value", out_result, model_sum(2'd2, 1'b1, b));
            @(negedge clk);
            chk("R8 burst third valid", {63'd0, out_valid}, 64'd1);
            chk("R8 burst third value", out_result, model_sum(2'd1, 1'b0, c));
            @(negedge clk);
            chk("R8 burst drained", {63'd0, out_valid}, 64'd0);
        end

        // R9: reset kills an in-flight strobe
        @(negedge clk);
        in_valid = 1'b1; in_size = 2'd0; in_wide = 1'b1; in_operand = '1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 valid cleared by reset", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        chk("R9 no late result", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule